// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block holds a small table of hardware thread contexts and services fork requests from a running context. When a fork arrives, the block takes the virtual processing element that the requesting context is bound to. It then scans the contexts in range for one that can be handed out. The first free context it finds gets the fork's restart address and one register value. The block also seeds that context's status from the forking thread's privilege mode and address-space identifier, and marks it active and dirty.

If no context can be handed out, the block records a thread exception cause and pulses a fault output. A simple write port presets each context's binding, allocatable, halted and active flags. A combinational read port shows any context's full state. Instruction decode and the architectural register file are outside this block.

Top module: `fork_alloc`

## Requirements
- R1: After reset every context reads back as bound to element 0, not allocatable, not halted, not active, not dirty, delay-slot flag 0, run state blocked (2'b01), mode 0, identifier 0, restart address 0 and register value 0; `fork_ok`, `fork_fault` and `exc_cause` are 0.
- R2: A preload write (`cfg_we`) sets the chosen context's binding, allocatable, halted and active flags from the `cfg_*` inputs, and resets its run state to blocked (2'b01), its delay-slot flag to 1 and its dirty flag to 0. The write shows on the read port in the next cycle. A preload write in the same cycle as `fork_req` is ignored.
- R3: Only contexts with an index from 0 to `max_ctx` inclusive are searched.
- R4: A context qualifies only when it is bound to the same element as context `req_id`, is allocatable, is not halted and is not active.
- R5: When several contexts qualify, the one with the lowest index is taken.
- R6: The chosen context's restart address takes `fork_pc` and its register value takes `fork_val`.
- R7: The chosen context's run state becomes running (2'b00), its delay-slot flag 0, its dirty flag 1 and its active flag 1; its mode takes `req_ksu` and its identifier takes `req_asid`. Its binding, allocatable and halted flags are unchanged.
- R8: When no context qualifies, `exc_cause` becomes 1 and keeps that value, `fork_fault` pulses, and no context changes.
- R9: Each fork gives exactly one one-cycle pulse in the cycle after the request, on `fork_ok` (with `fork_ctx` holding the chosen index) or on `fork_fault`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_ctx | input | 3 | Highest context index searched |
| fork_req | input | 1 | Fork request, one cycle |
| req_id | input | 3 | Index of the requesting context |
| req_ksu | input | 2 | Requester's privilege mode |
| req_asid | input | 8 | Requester's address-space identifier |
| fork_pc | input | 32 | Restart address for the new thread |
| fork_val | input | 32 | Value for the new thread's destination register |
| cfg_we | input | 1 | Preload write enable |
| cfg_idx | input | 3 | Preload target context |
| cfg_vpe | input | 2 | Preload binding |
| cfg_da | input | 1 | Preload allocatable flag |
| cfg_halt | input | 1 | Preload halted flag |
| cfg_act | input | 1 | Preload active flag |
| rd_idx | input | 3 | Read port context select |
| rd_vpe | output | 2 | Binding of the selected context |
| rd_da | output | 1 | Allocatable flag |
| rd_halt | output | 1 | Halted flag |
| rd_act | output | 1 | Active flag |
| rd_dirty | output | 1 | Dirty flag |
| rd_tds | output | 1 | Delay-slot flag |
| rd_rnst | output | 2 | Run state |
| rd_ksu | output | 2 | Privilege mode |
| rd_asid | output | 8 | Address-space identifier |
| rd_pc | output | 32 | Restart address |
| rd_val | output | 32 | Destination register value |
| fork_ok | output | 1 | Success pulse |
| fork_fault | output | 1 | Thread fault pulse |
| fork_ctx | output | 3 | Index of the context taken |
| exc_cause | output | 3 | Thread exception cause |

## Verification
The assertions check on every cycle that each fork gets exactly one response and that success and fault never coincide. They also check that a fault leaves every active flag as it was, that a fault shows cause 1, and that a reported context has just turned active. Only the bench scenarios can show that the search picks the lowest qualifying index, respects the element binding and the range limit, and loads the right address, value, mode and identifier. The bench covers these with directed cases and with random preloads and forks, each compared against a reference table.

// File: rtl/fork_alloc_pkg.sv
package fork_alloc_pkg;
    localparam int VPE_W   = 2;
    localparam int KSU_W   = 2;
    localparam int ASID_W  = 8;
    localparam int CAUSE_W = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NO_FREE = CAUSE_W'(1);

    typedef enum logic [1:0] {
        RS_RUN     = 2'b00,
        RS_BLOCKED = 2'b01,
        RS_YIELD   = 2'b10,
        RS_SUSPEND = 2'b11
    } run_state_e;

    typedef struct packed {
        logic [VPE_W-1:0]  vpe;
        logic              da;
        logic              halt;
        logic              act;
        logic              dirty;
        logic              tds;
        run_state_e        rnst;
        logic [KSU_W-1:0]  ksu;
        logic [ASID_W-1:0] asid;
    } ctx_stat_t;

    localparam ctx_stat_t CTX_RESET = '{
        vpe: '0, da: 1'b0, halt: 1'b0, act: 1'b0, dirty: 1'b0,
        tds: 1'b0, rnst: RS_BLOCKED, ksu: '0, asid: '0};

    function automatic logic ctx_free(input ctx_stat_t s);
        return s.da && !s.halt && !s.act;
    endfunction
endpackage

// File: rtl/fork_ctx_scan.sv
module fork_ctx_scan
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  ctx_stat_t        stat [NUM_CTX],
    input  logic [CTX_W-1:0] max_ctx,
    input  logic [CTX_W-1:0] req_id,
    output logic             hit,
    output logic [CTX_W-1:0] sel
);
    logic [VPE_W-1:0]   req_vpe;
    logic [NUM_CTX-1:0] elig;

    assign req_vpe = stat[req_id].vpe;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_elig
        assign elig[i] = (CTX_W'(i) <= max_ctx) &&
                         (stat[i].vpe == req_vpe) &&
                         ctx_free(stat[i]);
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                sel = CTX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fork_ctx_table.sv
module fork_ctx_table
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int PC_W    = 32,
    parameter int DATA_W  = 32,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [CTX_W-1:0]  cfg_idx,
    input  logic [VPE_W-1:0]  cfg_vpe,
    input  logic              cfg_da,
    input  logic              cfg_halt,
    input  logic              cfg_act,
    input  logic              ld_en,
    input  logic [CTX_W-1:0]  ld_idx,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [KSU_W-1:0]  ld_ksu,
    input  logic [ASID_W-1:0] ld_asid,
    output ctx_stat_t         stat_o [NUM_CTX],
    output logic [PC_W-1:0]   pc_o   [NUM_CTX],
    output logic [DATA_W-1:0] val_o  [NUM_CTX]
);
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        ctx_stat_t         stat_q;
        logic [PC_W-1:0]   pc_q;
        logic [DATA_W-1:0] val_q;
        logic              ld_hit, cfg_hit;

        assign ld_hit  = ld_en  && (ld_idx  == CTX_W'(i));
        assign cfg_hit = cfg_en && (cfg_idx == CTX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q <= CTX_RESET;
                pc_q   <= '0;
                val_q  <= '0;
            end else if (ld_hit) begin
                stat_q.rnst  <= RS_RUN;
                stat_q.tds   <= 1'b0;
                stat_q.dirty <= 1'b1;
                stat_q.act   <= 1'b1;
                stat_q.ksu   <= ld_ksu;
                stat_q.asid  <= ld_asid;
                pc_q         <= ld_pc;
                val_q        <= ld_val;
            end else if (cfg_hit) begin
                stat_q.vpe   <= cfg_vpe;
                stat_q.da    <= cfg_da;
                stat_q.halt  <= cfg_halt;
                stat_q.act   <= cfg_act;
                stat_q.rnst  <= RS_BLOCKED;
                stat_q.tds   <= 1'b1;
                stat_q.dirty <= 1'b0;
            end
        end

        assign stat_o[i] = stat_q;
        assign pc_o[i]   = pc_q;
        assign val_o[i]  = val_q;
    end
endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int PC_W    = 32,
    parameter int DATA_W  = 32,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTX_W-1:0]    max_ctx,
    input  logic                fork_req,
    input  logic [CTX_W-1:0]    req_id,
    input  logic [KSU_W-1:0]    req_ksu,
    input  logic [ASID_W-1:0]   req_asid,
    input  logic [PC_W-1:0]     fork_pc,
    input  logic [DATA_W-1:0]   fork_val,
    input  logic                cfg_we,
    input  logic [CTX_W-1:0]    cfg_idx,
    input  logic [VPE_W-1:0]    cfg_vpe,
    input  logic                cfg_da,
    input  logic                cfg_halt,
    input  logic                cfg_act,
    input  logic [CTX_W-1:0]    rd_idx,
    output logic [VPE_W-1:0]    rd_vpe,
    output logic                rd_da,
    output logic                rd_halt,
    output logic                rd_act,
    output logic                rd_dirty,
    output logic                rd_tds,
    output logic [1:0]          rd_rnst,
    output logic [KSU_W-1:0]    rd_ksu,
    output logic [ASID_W-1:0]   rd_asid,
    output logic [PC_W-1:0]     rd_pc,
    output logic [DATA_W-1:0]   rd_val,
    output logic                fork_ok,
    output logic                fork_fault,
    output logic [CTX_W-1:0]    fork_ctx,
    output logic [CAUSE_W-1:0]  exc_cause
);
    ctx_stat_t          stat [NUM_CTX];
    logic [PC_W-1:0]    pc_arr  [NUM_CTX];
    logic [DATA_W-1:0]  val_arr [NUM_CTX];
    logic [NUM_CTX-1:0] act_vec;
    logic               hit;
    logic [CTX_W-1:0]   sel;
    logic               cfg_en;
    logic               ok_q, fault_q;
    logic [CTX_W-1:0]   ctx_q;
    logic [CAUSE_W-1:0] cause_q;

    assign cfg_en = cfg_we && !fork_req;

    fork_ctx_scan #(.NUM_CTX(NUM_CTX)) u_scan (
        .stat    (stat),
        .max_ctx (max_ctx),
        .req_id  (req_id),
        .hit     (hit),
        .sel     (sel)
    );

    fork_ctx_table #(.NUM_CTX(NUM_CTX), .PC_W(PC_W), .DATA_W(DATA_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_idx  (cfg_idx),
        .cfg_vpe  (cfg_vpe),
        .cfg_da   (cfg_da),
        .cfg_halt (cfg_halt),
        .cfg_act  (cfg_act),
        .ld_en    (fork_req && hit),
        .ld_idx   (sel),
        .ld_pc    (fork_pc),
        .ld_val   (fork_val),
        .ld_ksu   (req_ksu),
        .ld_asid  (req_asid),
        .stat_o   (stat),
        .pc_o     (pc_arr),
        .val_o    (val_arr)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_act
        assign act_vec[i] = stat[i].act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q    <= 1'b0;
            fault_q <= 1'b0;
            ctx_q   <= '0;
            cause_q <= '0;
        end else begin
            ok_q    <= fork_req && hit;
            fault_q <= fork_req && !hit;
            if (fork_req && hit) begin
                ctx_q <= sel;
            end
            if (fork_req && !hit) begin
                cause_q <= CAUSE_NO_FREE;
            end
        end
    end

    assign fork_ok    = ok_q;
    assign fork_fault = fault_q;
    assign fork_ctx   = ctx_q;
    assign exc_cause  = cause_q;

    assign rd_vpe   = stat[rd_idx].vpe;
    assign rd_da    = stat[rd_idx].da;
    assign rd_halt  = stat[rd_idx].halt;
    assign rd_act   = stat[rd_idx].act;
    assign rd_dirty = stat[rd_idx].dirty;
    assign rd_tds   = stat[rd_idx].tds;
    assign rd_rnst  = stat[rd_idx].rnst;
    assign rd_ksu   = stat[rd_idx].ksu;
    assign rd_asid  = stat[rd_idx].asid;
    assign rd_pc    = pc_arr[rd_idx];
    assign rd_val   = val_arr[rd_idx];
endmodule

// File: rtl/fork_alloc_chk.sv
module fork_alloc_chk
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input logic               clk,
    input logic               rst,
    input logic               fork_req,
    input logic               fork_ok,
    input logic               fork_fault,
    input logic [CTX_W-1:0]   fork_ctx,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [NUM_CTX-1:0] act_vec
);
    logic [NUM_CTX-1:0] act_prev;

    always_ff @(posedge clk) begin
        if (rst) act_prev <= '0;
        else     act_prev <= act_vec;
    end

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fork_ok && fork_fault));

    a_r9_one_response: assert property (@(posedge clk) disable iff (rst)
        fork_req |=> (fork_ok || fork_fault));

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (fork_ok || fork_fault) |-> $past(fork_req));

    a_r8_cause_set: assert property (@(posedge clk) disable iff (rst)
        fork_fault |-> (exc_cause == CAUSE_NO_FREE));

    a_r8_no_change: assert property (@(posedge clk) disable iff (rst)
        fork_fault |-> (act_vec == act_prev));

    a_r7_newly_active: assert property (@(posedge clk) disable iff (rst)
        fork_ok |-> (act_vec[fork_ctx] && !act_prev[fork_ctx]));
endmodule

bind fork_alloc fork_alloc_chk #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fork_req   (fork_req),
    .fork_ok    (fork_ok),
    .fork_fault (fork_fault),
    .fork_ctx   (fork_ctx),
    .exc_cause  (exc_cause),
    .act_vec    (act_vec)
);

// File: tb/fork_alloc_bench.sv
module fork_alloc_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  max_ctx;
    logic        fork_req;
    logic [2:0]  req_id;
    logic [1:0]  req_ksu;
    logic [7:0]  req_asid;
    logic [31:0] fork_pc, fork_val;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [1:0]  cfg_vpe;
    logic        cfg_da, cfg_halt, cfg_act;
    logic [2:0]  rd_idx;
    logic [1:0]  rd_vpe;
    logic        rd_da, rd_halt, rd_act, rd_dirty, rd_tds;
    logic [1:0]  rd_rnst, rd_ksu;
    logic [7:0]  rd_asid;
    logic [31:0] rd_pc, rd_val;
    logic        fork_ok, fork_fault;
    logic [2:0]  fork_ctx, exc_cause;

    fork_alloc u_fork_alloc (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]  m_vpe [N];
    logic        m_da [N], m_halt [N], m_act [N], m_dirty [N], m_tds [N];
    logic [1:0]  m_rnst [N], m_ksu [N];
    logic [7:0]  m_asid [N];
    logic [31:0] m_pc [N], m_val [N];
    logic [2:0]  m_exc;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ctx(input int i, input string req);
        rd_idx = 3'(i);
        #1;
        check({req, " vpe"},   64'(rd_vpe),   64'(m_vpe[i]));
        check({req, " da"},    64'(rd_da),    64'(m_da[i]));
        check({req, " halt"},  64'(rd_halt),  64'(m_halt[i]));
        check({req, " act"},   64'(rd_act),   64'(m_act[i]));
        check({req, " dirty"}, 64'(rd_dirty), 64'(m_dirty[i]));
        check({req, " tds"},   64'(rd_tds),   64'(m_tds[i]));
        check({req, " rnst"},  64'(rd_rnst),  64'(m_rnst[i]));
        check({req, " ksu"},   64'(rd_ksu),   64'(m_ksu[i]));
        check({req, " asid"},  64'(rd_asid),  64'(m_asid[i]));
        check({req, " pc"},    64'(rd_pc),    64'(m_pc[i]));
        check({req, " val"},   64'(rd_val),   64'(m_val[i]));
    endtask

    function automatic int pick(input int id, input int mx);
        for (int i = 0; i <= mx; i++) begin
            if (m_vpe[i] == m_vpe[id] && m_da[i] && !m_halt[i] && !m_act[i])
                return i;
        end
        return -1;
    endfunction

    task automatic preload(input int i, input logic [1:0] v, input logic d,
                           input logic h, input logic a);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(i); cfg_vpe = v; cfg_da = d; cfg_halt = h; cfg_act = a;
        @(negedge clk);
        cfg_we = 0;
        m_vpe[i] = v; m_da[i] = d; m_halt[i] = h; m_act[i] = a;
        m_rnst[i] = 2'b01; m_tds[i] = 1'b1; m_dirty[i] = 1'b0;
    endtask

    task automatic do_fork(input int id, input int mx, input logic [1:0] k,
                           input logic [7:0] as, input logic [31:0] pc,
                           input logic [31:0] v, input bit with_cfg);
        int sel;
        sel = pick(id, mx);
        @(negedge clk);
        max_ctx = 3'(mx); req_id = 3'(id); req_ksu = k; req_asid = as;
        fork_pc = pc; fork_val = v; fork_req = 1;
        if (with_cfg) begin
            cfg_we = 1; cfg_idx = 3'(N - 1); cfg_vpe = ~m_vpe[N-1];
            cfg_da = ~m_da[N-1]; cfg_halt = ~m_halt[N-1]; cfg_act = ~m_act[N-1];
        end
        @(negedge clk);
        fork_req = 0; cfg_we = 0;
        #1;
        if (sel >= 0) begin
            check("R9 ok pulse", 64'(fork_ok), 64'd1);
            check("R9 no fault", 64'(fork_fault), 64'd0);
            check("R5 R3 R4 chosen ctx", 64'(fork_ctx), 64'(sel));
            m_pc[sel] = pc; m_val[sel] = v; m_rnst[sel] = 2'b00; m_tds[sel] = 0;
            m_dirty[sel] = 1; m_act[sel] = 1; m_ksu[sel] = k; m_asid[sel] = as;
            check_ctx(sel, "R6 R7 loaded ctx");
        end else begin
            m_exc = 3'd1;
            check("R8 fault pulse", 64'(fork_fault), 64'd1);
            check("R9 no ok", 64'(fork_ok), 64'd0);
            for (int i = 0; i < N; i++) check_ctx(i, "R8 unchanged");
        end
        check("R8 cause", 64'(exc_cause), 64'(m_exc));
        if (with_cfg) check_ctx(N - 1, "R2 cfg ignored during fork");
        @(negedge clk);
        check("R9 single pulse ok", 64'(fork_ok), 64'd0);
        check("R9 single pulse fault", 64'(fork_fault), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; max_ctx = 3'd7; fork_req = 0; req_id = 0; req_ksu = 0; req_asid = 0;
        fork_pc = 0; fork_val = 0; cfg_we = 0; cfg_idx = 0; cfg_vpe = 0;
        cfg_da = 0; cfg_halt = 0; cfg_act = 0; rd_idx = 0;
        for (int i = 0; i < N; i++) begin
            m_vpe[i] = 0; m_da[i] = 0; m_halt[i] = 0; m_act[i] = 0; m_dirty[i] = 0;
            m_tds[i] = 0; m_rnst[i] = 2'b01; m_ksu[i] = 0; m_asid[i] = 0;
            m_pc[i] = 0; m_val[i] = 0;
        end
        m_exc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 ok idle", 64'(fork_ok), 64'd0);
        check("R1 fault idle", 64'(fork_fault), 64'd0);
        check("R1 cause", 64'(exc_cause), 64'd0);
        for (int i = 0; i < N; i++) check_ctx(i, "R1 reset ctx");

        // R8 nothing allocatable after reset
        do_fork(0, 7, 2'd1, 8'h11, 32'h1000, 32'hA, 0);

        // R2 preload and readback
        preload(0, 2'd1, 1, 0, 1);
        preload(2, 2'd1, 1, 0, 0);
        preload(3, 2'd1, 1, 1, 0);
        preload(4, 2'd0, 1, 0, 0);
        preload(5, 2'd1, 1, 0, 0);
        preload(6, 2'd1, 0, 0, 0);
        for (int i = 0; i < N; i++) check_ctx(i, "R2 preload");

        // R5 lowest (2), R4 skips halted 3 and other-element 4
        do_fork(0, 7, 2'd2, 8'h5A, 32'h8000_0040, 32'hDEAD_BEEF, 0);
        do_fork(0, 7, 2'd3, 8'hC3, 32'h8000_0080, 32'h1234_5678, 0);
        // R3: only 6 remaining on element 1 is not allocatable; range cut
        preload(7, 2'd1, 1, 0, 0);
        do_fork(0, 6, 2'd0, 8'h01, 32'h44, 32'h55, 0);
        // R2 cfg ignored during fork; 7 in range
        do_fork(0, 7, 2'd1, 8'h77, 32'h88, 32'h99, 1);
        // R4 other element requester
        do_fork(1, 7, 2'd1, 8'h22, 32'h1, 32'h2, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) != 0)
                preload($urandom_range(0, N - 1), 2'($urandom_range(0, 3)),
                        1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                        ($urandom_range(0, 2) == 0));
            else
                do_fork($urandom_range(0, N - 1), $urandom_range(0, N - 1),
                        2'($urandom), 8'($urandom), $urandom, $urandom,
                        ($urandom_range(0, 4) == 0));
        end
        for (int i = 0; i < N; i++) check_ctx(i, "R6 final table");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule